// File: doc/BRIEF.md
# OSD Frame Control Register with Blink Timer

This block holds the frame-level control byte of an on-screen display. One byte-wide register carries a fade enable, a handshake with an external size-measurement engine, and a five-bit blink period. The host reaches the register over a simple bus with an address, a write strobe, write data and read data.

The host starts a measurement by writing 1 to the start bit. The block raises `meas_start_o` toward the engine. When the engine pulses `meas_done_i`, the start bit clears itself and a done flag rises. The host clears the done flag when it starts a new measurement. A separate one-cycle calibration pulse also clears it.

A field counter advances on each vertical field pulse. Each time the count reaches eight times the programmed period, the blink phase toggles. A period of zero parks the phase in the shown state. All pins are plain control and status levels or pulses. No data stream passes through the block, so no valid/ready handshake or back-pressure applies.

Top module: `osd_frame_ctrl`

## Requirements
- R1: A synchronous active-high reset clears the fade bit, start bit, done flag, period field, field counter and blink phase. Every output, including `bus_rdata`, then reads 0.
- R2: A write to the register address loads bit 0 into the fade enable. `fade_en_o` shows it from the next cycle.
- R3: Writing 1 to bit 1 sets the start bit (`meas_start_o`) on the next cycle. Writing 0 to bit 1 leaves the start bit as it was.
- R4: When `meas_done_i` pulses while the start bit is 1, the next cycle shows the start bit at 0 and the done flag (bit 2, `meas_valid_o`) at 1. A `meas_done_i` pulse while the start bit is 0 has no effect.
- R5: Writing 1 to bit 1 clears the done flag on the next cycle. This write wins over a `meas_done_i` pulse in the same cycle, so the result is start=1 and done=0.
- R6: A `cal_clr_i` pulse clears the done flag on the next cycle. If `meas_done_i` sets the flag in the same cycle, the flag ends up set.
- R7: The value written to bit 2 never changes the done flag.
- R8: Bits 7:3 hold the period P. With P nonzero, the blink phase (`blink_phase_o`, 0 = shown, 1 = hidden) toggles on the cycle after the field pulse that brings the count to 8·P. The count then restarts from zero.
- R9: While P is 0, the field counter stays at 0 and the blink phase reads 0 from the next cycle on, whatever field pulses arrive.
- R10: A read at `REG_ADDR` returns {P, done, start, fade} in bits 7:3, 2, 1 and 0. A read at any other address returns 0, and a write to another address changes nothing.
- R11: `bus_rdata` is combinational from `bus_addr` and the current register state. A value written at one edge is readable in the cycle right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | ADDR_W | Register bus address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 3+PER_W | Write data |
| bus_rdata | output | 3+PER_W | Read data, combinational |
| meas_done_i | input | 1 | One-cycle pulse: measurement finished |
| cal_clr_i | input | 1 | One-cycle pulse: calibration programmed, clears done |
| field_pulse_i | input | 1 | One-cycle pulse per vertical field |
| fade_en_o | output | 1 | Fade function enable |
| meas_start_o | output | 1 | Measurement request (start bit) |
| meas_valid_o | output | 1 | Measurement results valid (done flag) |
| blink_phase_o | output | 1 | Blink phase, 0 = shown |

## Verification
Every register output (fade, start, done, phase) is due one clock after the write or pulse that causes it. A blink toggle is due one clock after the field pulse that completes 8·P counts. Read data is due in the same cycle as the address.

The bench drives inputs on the falling edge and updates its behavioural model at each rising edge. It compares all outputs at the next falling edge, which is exactly one register stage after the stimulus. Read data is compared against the current address in that same half cycle.

// File: rtl/osd_fc_pkg.sv
package osd_fc_pkg;
  localparam int FADE_BIT  = 0;
  localparam int START_BIT = 1;
  localparam int DONE_BIT  = 2;
  localparam int PER_LSB   = 3;
endpackage

// File: rtl/osd_fc_regs.sv
module osd_fc_regs
  import osd_fc_pkg::*;
#(
  parameter int PER_W = 5
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_hit,
  input  logic [PER_LSB+PER_W-1:0] wdata,
  input  logic                     meas_done_i,
  input  logic                     cal_clr_i,
  output logic                     fade_o,
  output logic                     start_o,
  output logic                     done_o,
  output logic [PER_W-1:0]         period_o
);
  logic             fade_q, start_q, done_q;
  logic [PER_W-1:0] period_q;
  logic             host_start;

  assign host_start = wr_hit && wdata[START_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      fade_q   <= 1'b0;
      start_q  <= 1'b0;
      done_q   <= 1'b0;
      period_q <= '0;
    end else begin
      if (wr_hit) begin
        fade_q   <= wdata[FADE_BIT];
        period_q <= wdata[PER_LSB +: PER_W];
      end
      if (host_start) begin
        start_q <= 1'b1;
        done_q  <= 1'b0;
      end else if (meas_done_i && start_q) begin
        start_q <= 1'b0;
        done_q  <= 1'b1;
      end else if (cal_clr_i) begin
        done_q  <= 1'b0;
      end
    end
  end

  assign fade_o   = fade_q;
  assign start_o  = start_q;
  assign done_o   = done_q;
  assign period_o = period_q;

  // R3
  start_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(start_q) |-> $past(meas_done_i));
  // R4
  done_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(done_q) |-> $past(meas_done_i && start_q));
  // R5
  host_start_chk: assert property (@(posedge clk) disable iff (rst)
    host_start |=> (start_q && !done_q));
  // R6
  cal_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (cal_clr_i && !meas_done_i) |=> !done_q);
endmodule

// File: rtl/osd_fc_blink.sv
module osd_fc_blink #(
  parameter int PER_W     = 5,
  parameter int UNIT_LOG2 = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PER_W-1:0] period,
  input  logic             field_pulse_i,
  output logic             phase_o
);
  localparam int CNT_W = PER_W + UNIT_LOG2;

  logic [CNT_W-1:0] cnt_q, cnt_inc, limit;
  logic             phase_q;

  assign limit   = {period, {UNIT_LOG2{1'b0}}};
  assign cnt_inc = cnt_q + {{(CNT_W-1){1'b0}}, 1'b1};

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      phase_q <= 1'b0;
    end else if (period == '0) begin
      cnt_q   <= '0;
      phase_q <= 1'b0;
    end else if (field_pulse_i) begin
      if (cnt_inc >= limit) begin
        cnt_q   <= '0;
        phase_q <= ~phase_q;
      end else begin
        cnt_q   <= cnt_inc;
      end
    end
  end

  assign phase_o = phase_q;

  // R8
  phase_move_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(phase_q) |-> ($past(field_pulse_i) || $past(period == '0)));
  // R9
  zero_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (period == '0) |=> (!phase_q && cnt_q == '0));
endmodule

// File: rtl/osd_frame_ctrl.sv
module osd_frame_ctrl
  import osd_fc_pkg::*;
#(
  parameter int          ADDR_W    = 8,
  parameter logic [7:0]  REG_ADDR  = 8'h21,
  parameter int          PER_W     = 5,
  parameter int          UNIT_LOG2 = 3
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic                     bus_wr,
  input  logic [PER_LSB+PER_W-1:0] bus_wdata,
  output logic [PER_LSB+PER_W-1:0] bus_rdata,
  input  logic                     meas_done_i,
  input  logic                     cal_clr_i,
  input  logic                     field_pulse_i,
  output logic                     fade_en_o,
  output logic                     meas_start_o,
  output logic                     meas_valid_o,
  output logic                     blink_phase_o
);
  localparam int DATA_W = PER_LSB + PER_W;

  logic             addr_hit;
  logic             fade, start, done;
  logic [PER_W-1:0] period;

  assign addr_hit = (bus_addr == ADDR_W'(REG_ADDR));

  osd_fc_regs #(.PER_W(PER_W)) regs_i (
    .clk         (clk),
    .rst         (rst),
    .wr_hit      (bus_wr && addr_hit),
    .wdata       (bus_wdata),
    .meas_done_i (meas_done_i),
    .cal_clr_i   (cal_clr_i),
    .fade_o      (fade),
    .start_o     (start),
    .done_o      (done),
    .period_o    (period)
  );

  osd_fc_blink #(.PER_W(PER_W), .UNIT_LOG2(UNIT_LOG2)) blink_i (
    .clk           (clk),
    .rst           (rst),
    .period        (period),
    .field_pulse_i (field_pulse_i),
    .phase_o       (blink_phase_o)
  );

  always_comb begin
    bus_rdata = '0;
    if (addr_hit) begin
      bus_rdata[FADE_BIT]            = fade;
      bus_rdata[START_BIT]           = start;
      bus_rdata[DONE_BIT]            = done;
      bus_rdata[PER_LSB +: PER_W]    = period;
    end
  end

  assign fade_en_o    = fade;
  assign meas_start_o = start;
  assign meas_valid_o = done;

  // R10
  foreign_write_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && !addr_hit && !meas_done_i && !cal_clr_i) |=> $stable(fade_en_o) && $stable(meas_start_o) && $stable(meas_valid_o));

  logic unused_ok;
  assign unused_ok = ^{DATA_W};
endmodule

// File: tb/osd_frame_ctrl_tb.sv
module osd_frame_ctrl_tb_top;
  localparam int         ADDR_W = 8;
  localparam logic [7:0] RADDR  = 8'h21;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       meas_done_i = 1'b0, cal_clr_i = 1'b0, field_pulse_i = 1'b0;
  logic       fade_en_o, meas_start_o, meas_valid_o, blink_phase_o;

  int vectors = 0;
  int errors  = 0;

  always #5ns clk = ~clk;

  osd_frame_ctrl #(.ADDR_W(ADDR_W), .REG_ADDR(RADDR)) dut_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .meas_done_i(meas_done_i), .cal_clr_i(cal_clr_i), .field_pulse_i(field_pulse_i),
    .fade_en_o(fade_en_o), .meas_start_o(meas_start_o),
    .meas_valid_o(meas_valid_o), .blink_phase_o(blink_phase_o)
  );

  // behavioural reference model
  int m_fade = 0, m_start = 0, m_done = 0, m_per = 0, m_cnt = 0, m_ph = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_fade = 0; m_start = 0; m_done = 0; m_per = 0; m_cnt = 0; m_ph = 0;
    end else begin
      int old_per;
      old_per = m_per;
      if (old_per == 0) begin
        m_cnt = 0; m_ph = 0;
      end else if (field_pulse_i) begin
        m_cnt = m_cnt + 1;
        if (m_cnt >= old_per * 8) begin
          m_cnt = 0; m_ph = 1 - m_ph;
        end
      end
      if (bus_wr && bus_addr == RADDR && bus_wdata[1]) begin
        m_start = 1; m_done = 0;
      end else if (meas_done_i && m_start == 1) begin
        m_start = 0; m_done = 1;
      end else if (cal_clr_i) begin
        m_done = 0;
      end
      if (bus_wr && bus_addr == RADDR) begin
        m_fade = int'(bus_wdata[0]);
        m_per  = int'(bus_wdata[7:3]);
      end
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    int exp_rd;
    exp_rd = (bus_addr == RADDR) ? (m_per * 8 + m_done * 4 + m_start * 2 + m_fade) : 0;
    check("R2 fade_en_o", int'(fade_en_o), m_fade);
    check("R3 R4 meas_start_o", int'(meas_start_o), m_start);
    check("R4 R5 R6 R7 meas_valid_o", int'(meas_valid_o), m_done);
    check("R8 R9 blink_phase_o", int'(blink_phase_o), m_ph);
    check("R10 R11 bus_rdata", int'(bus_rdata), exp_rd);
  endtask

  task automatic step();
    @(negedge clk);
    compare_all();
    bus_wr = 1'b0; meas_done_i = 1'b0; cal_clr_i = 1'b0; field_pulse_i = 1'b0;
    bus_addr = RADDR;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
    step();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    bus_addr = RADDR;
    #1ns;
    // R1 reset state
    check("R1 rdata in reset", int'(bus_rdata), 0);
    check("R1 outputs in reset", int'({fade_en_o, meas_start_o, meas_valid_o, blink_phase_o}), 0);
    rst = 1'b0;
    step();

    wr(RADDR, 8'h01);                       // R2 fade on
    wr(RADDR, 8'h00);                       // R2 fade off
    meas_done_i = 1'b1; step();             // R4 ignored while idle
    wr(RADDR, 8'h02);                       // R3 start
    wr(RADDR, 8'h00);                       // R3 writing 0 keeps start
    meas_done_i = 1'b1; step();             // R4 complete
    check("R4 done set", int'(meas_valid_o), 1);
    wr(RADDR, 8'h04);                       // R7 done bit write ignored
    wr(RADDR, 8'h00);
    check("R7 done unchanged", int'(meas_valid_o), 1);
    cal_clr_i = 1'b1; step();               // R6 cal clear
    check("R6 done cleared", int'(meas_valid_o), 0);
    wr(RADDR, 8'h02);
    meas_done_i = 1'b1; cal_clr_i = 1'b1; step();   // R6 complete wins
    check("R6 complete wins", int'(meas_valid_o), 1);
    bus_addr = RADDR; bus_wr = 1'b1; bus_wdata = 8'h02; meas_done_i = 1'b1; step(); // R5
    check("R5 host start wins", int'({meas_start_o, meas_valid_o}), 2);
    meas_done_i = 1'b1; step();
    wr(8'h20, 8'hFF);                        // R10 foreign address ignored
    bus_addr = 8'h20; #1ns;
    check("R10 foreign read", int'(bus_rdata), 0);
    step();

    // R8 period 1: toggle every 8 pulses
    wr(RADDR, 8'h08);
    for (int i = 0; i < 40; i++) begin field_pulse_i = 1'b1; step(); end
    // R8 period 3 with sparse pulses
    wr(RADDR, 8'h18);
    for (int i = 0; i < 200; i++) begin field_pulse_i = (i % 3 == 0); step(); end
    // R8 largest period
    wr(RADDR, 8'hF8);
    for (int i = 0; i < 520; i++) begin field_pulse_i = 1'b1; step(); end
    // R9 period 0 holds shown
    wr(RADDR, 8'h00);
    for (int i = 0; i < 30; i++) begin field_pulse_i = 1'b1; step(); end
    check("R9 phase held", int'(blink_phase_o), 0);

    // mixed random traffic
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = int'($urandom_range(0, 99));
      bus_addr      = (r < 90) ? RADDR : 8'($urandom);
      bus_wr        = ($urandom_range(0, 9) == 0);
      bus_wdata     = ($urandom_range(0, 3) == 0) ? 8'($urandom) : (8'($urandom) & 8'h0D);
      meas_done_i   = ($urandom_range(0, 7) == 0);
      cal_clr_i     = ($urandom_range(0, 11) == 0);
      field_pulse_i = ($urandom_range(0, 1) == 0);
      step();
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #1ms;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule